// File: doc/BRIEF.md
# Bidirectional Lag Delay Line

This block supplies the lagged sample pairs for a sixteen-lag, two-bit correlator. Two eight-stage chains of two-bit codes move in opposite directions. The x chain enters at stage 0 and moves toward stage 7. The y chain enters at stage 7 and moves toward stage 0. Each stage output feeds two lag pairs, so one shift per sample clock gives sixteen pairs with consecutive relative delays. Lag spacing is one sample interval.

A four-way selector picks the entry sample of each chain, which lets chips be cascaded or fed back. A per-chain option inserts one extra register at the entry. This makes up the delay that is lost when a shifted output is fed back locally. A second per-chain option moves the cascade output tap one stage earlier, so that an external resynchronising register between boards keeps the total delay unchanged. Multiplication and accumulation are handled downstream.

Top module: `lag_delay_line`

## Requirements
- R1: Reset (rst_n low, asynchronous) sets every chain stage and both entry delay registers to code 2'b00 (sign 0, magnitude 0). While it lasts, every lag output except lag_y pair 15 reads 2'b00, and so do both cascade outputs.
- R2: The x entry sample moves one stage per clock. Stage i holds the x entry from i+1 edges earlier, and lag_x pair k (bits [2k+1:2k]) shows x stage floor(k/2).
- R3: The y chain moves the opposite way. Stage j holds the y entry from 8-j edges earlier. lag_y pair k shows y stage ceil(k/2), and pair 15 shows the present y entry sample.
- R4: In lag pair k, the x sample is k-7 samples older than the y sample. A sample that enters both chains on the same edge lines up in pair 7 only, four edges later.
- R5: The entry sample of each chain is candidate n, chosen by the 2-bit select equal to n. Candidate n sits at bits [2n+1:2n] of the candidate bus.
- R6: While a chain's extra-delay input is high, its entry sample is the selector output registered one edge earlier.
- R7: x_cas shows x stage 7, or x stage 6 while x_early is high.
- R8: y_cas shows y stage 0, or y stage 1 while y_early is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_cand | input | 8 | Four 2-bit x candidate samples |
| x_sel | input | 2 | x candidate select |
| x_xdly | input | 1 | Insert extra delay at x entry |
| x_early | input | 1 | Move x cascade tap one stage earlier |
| y_cand | input | 8 | Four 2-bit y candidate samples |
| y_sel | input | 2 | y candidate select |
| y_xdly | input | 1 | Insert extra delay at y entry |
| y_early | input | 1 | Move y cascade tap one stage earlier |
| lag_x | output | 32 | x sample of lag pairs 0..15 |
| lag_y | output | 32 | y sample of lag pairs 0..15 |
| x_cas | output | 2 | x cascade output |
| y_cas | output | 2 | y cascade output |

## Verification
Two functions can act in the same cycle. A change of selector or extra-delay setting can occur on the same edge that shifts the older samples along the chain. An option switch can also coincide with a tap move on the cascade output. The stimulus table and a pseudo-random sweep toggle select, delay and tap inputs on every step while the chains are full of distinct codes. A bench model built from delayed copies of the two entry streams then judges all sixteen pairs and both cascade outputs. This shows that the new setting affects only the next entry or the present tap and never the samples already held.

// File: rtl/lag_delay_line.sv
module lag_delay_line #(
  parameter int STAGES = 8,
  parameter int SW     = 2,
  parameter int NSRC   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC*SW-1:0]   x_cand,
  input  logic [$clog2(NSRC)-1:0] x_sel,
  input  logic                 x_xdly,
  input  logic                 x_early,
  input  logic [NSRC*SW-1:0]   y_cand,
  input  logic [$clog2(NSRC)-1:0] y_sel,
  input  logic                 y_xdly,
  input  logic                 y_early,
  output logic [2*STAGES*SW-1:0] lag_x,
  output logic [2*STAGES*SW-1:0] lag_y,
  output logic [SW-1:0]        x_cas,
  output logic [SW-1:0]        y_cas
);
  localparam int LAGS = 2 * STAGES;

  logic [SW-1:0] xs [STAGES];
  logic [SW-1:0] ys [STAGES];
  logic [SW-1:0] xd, yd, xm, ym, ex, ey;
  logic          live;

  assign xm = x_cand[x_sel*SW +: SW];
  assign ym = y_cand[y_sel*SW +: SW];
  assign ex = x_xdly ? xd : xm;
  assign ey = y_xdly ? yd : ym;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        xs[i] <= '0;
        ys[i] <= '0;
      end
      xd   <= '0;
      yd   <= '0;
      live <= 1'b0;
    end else begin
      xs[0]        <= ex;
      ys[STAGES-1] <= ey;
      for (int i = 1; i < STAGES; i++) xs[i] <= xs[i-1];
      for (int j = 0; j < STAGES-1; j++) ys[j] <= ys[j+1];
      xd   <= xm;
      yd   <= ym;
      live <= 1'b1;
    end
  end

  for (genvar k = 0; k < LAGS; k++) begin : g_lag
    assign lag_x[k*SW +: SW] = xs[k/2];
    if ((k+1)/2 == STAGES) begin : g_entry
      assign lag_y[k*SW +: SW] = ey;
    end else begin : g_stage
      assign lag_y[k*SW +: SW] = ys[(k+1)/2];
    end
  end

  assign x_cas = x_early ? xs[STAGES-2] : xs[STAGES-1];
  assign y_cas = y_early ? ys[1] : ys[0];

  AST_X_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> lag_x[LAGS*SW-1:2*SW] == $past(lag_x[(LAGS-2)*SW-1:0])); // R2
  AST_Y_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> lag_y[(LAGS-2)*SW-1:0] == $past(lag_y[LAGS*SW-1:2*SW])); // R3
  AST_X_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$past(x_xdly)) |-> lag_x[SW-1:0] == $past(xm)); // R5
  AST_Y_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
    (live && y_xdly) |-> lag_y[(LAGS-1)*SW +: SW] == $past(ym)); // R6
  AST_XCAS_TAP: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> x_cas == (x_early ? $past(lag_x[(LAGS-6)*SW +: SW])
                               : $past(lag_x[(LAGS-4)*SW +: SW]))); // R7
  AST_YCAS_TAP: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> y_cas == (y_early ? $past(lag_y[4*SW +: SW])
                               : $past(lag_y[2*SW +: SW]))); // R8
endmodule

// File: tb/lag_delay_line_test.sv
module lag_delay_line_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] x_cand = '0, y_cand = '0;
  logic [1:0] x_sel = '0, y_sel = '0;
  logic x_xdly = 1'b0, y_xdly = 1'b0, x_early = 1'b0, y_early = 1'b0;
  logic [31:0] lag_x, lag_y;
  logic [1:0] x_cas, y_cas;

  int errors = 0;
  int checks = 0;

  logic [1:0] xh [8];
  logic [1:0] yh [8];
  logic [1:0] xd_ref, yd_ref;

  always #2.5 clk = ~clk;

  lag_delay_line uut (
    .clk(clk), .rst_n(rst_n),
    .x_cand(x_cand), .x_sel(x_sel), .x_xdly(x_xdly), .x_early(x_early),
    .y_cand(y_cand), .y_sel(y_sel), .y_xdly(y_xdly), .y_early(y_early),
    .lag_x(lag_x), .lag_y(lag_y), .x_cas(x_cas), .y_cas(y_cas)
  );

  // {x_cand, x_sel, y_cand, y_sel, x_xdly, y_xdly, x_early, y_early}
  localparam logic [23:0] VEC [16] = '{
    24'hE4_0_1B_0, 24'h1B_4_E4_1, 24'hFF_8_00_2, 24'h00_C_FF_3,
    24'h93_1_6C_4, 24'h6C_5_93_8, 24'h27_9_D8_C, 24'hD8_D_27_F,
    24'hA5_2_5A_6, 24'h5A_6_A5_9, 24'h36_A_C9_5, 24'hC9_E_36_A,
    24'h1E_3_E1_0, 24'hE1_7_1E_F, 24'h4B_B_B4_3, 24'hB4_F_4B_C
  };

  function automatic logic [1:0] xm_f();
    return x_cand[x_sel*2 +: 2];
  endfunction
  function automatic logic [1:0] ym_f();
    return y_cand[y_sel*2 +: 2];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [23:0] v);
    {x_cand, x_sel, y_cand, y_sel, x_xdly, y_xdly, x_early, y_early} = v;
  endtask

  task automatic model_clear();
    for (int i = 0; i < 8; i++) begin xh[i] = '0; yh[i] = '0; end
    xd_ref = '0; yd_ref = '0;
  endtask

  task automatic compare_all();
    logic [31:0] ex_x, ex_y;
    logic [1:0] ey_now;
    ey_now = y_xdly ? yd_ref : ym_f();
    for (int k = 0; k < 16; k++) begin
      ex_x[k*2 +: 2] = xh[k/2];
      ex_y[k*2 +: 2] = ((k+1)/2 == 8) ? ey_now : yh[7-(k+1)/2];
    end
    check("R2 lag_x", lag_x, ex_x);
    check("R3 lag_y", lag_y, ex_y);
    check("R7 x_cas", {30'd0, x_cas}, {30'd0, x_early ? xh[6] : xh[7]});
    check("R8 y_cas", {30'd0, y_cas}, {30'd0, y_early ? yh[6] : yh[7]});
  endtask

  task automatic step(input logic [23:0] v);
    logic [1:0] ex, ey;
    apply(v);
    @(posedge clk);
    ex = x_xdly ? xd_ref : xm_f();
    ey = y_xdly ? yd_ref : ym_f();
    for (int i = 7; i > 0; i--) begin xh[i] = xh[i-1]; yh[i] = yh[i-1]; end
    xh[0] = ex; yh[0] = ey;
    xd_ref = xm_f(); yd_ref = ym_f();
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    apply('0);
    rst_n = 1'b0;
    model_clear();
    #1;
    check("R1 reset lag_x", lag_x, '0);
    check("R1 reset lag_y", lag_y, '0);
    check("R1 reset cascade", {28'd0, x_cas, y_cas}, '0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [23:0] lfsr;
    int hits;
    model_clear();
    repeat (2) @(negedge clk);
    do_reset();

    foreach (VEC[i]) step(VEC[i]);

    // R5: candidate n = code n, select each in turn
    for (int s = 0; s < 4; s++) begin
      step({8'hE4, 2'(s), 8'h00, 2'd0, 4'h0});
      check("R5 select lag_x pair0", {30'd0, lag_x[1:0]}, s);
    end

    // R6: extra delay on y shows previous selector output
    step({8'h00, 2'd0, 8'h02, 2'd0, 4'h4});
    apply({8'h00, 2'd0, 8'h01, 2'd0, 4'h4});
    #1;
    check("R6 y extra delay pair15", {30'd0, lag_y[31:30]}, 32'd2);
    step({8'h00, 2'd0, 8'h01, 2'd0, 4'h4});

    // R4: impulse enters both chains together
    do_reset();
    step({8'h03, 2'd0, 8'h03, 2'd0, 4'h0});
    repeat (3) step('0);
    hits = 0;
    for (int k = 0; k < 16; k++)
      if (lag_x[k*2 +: 2] == 2'b11 && lag_y[k*2 +: 2] == 2'b11) hits++;
    check("R4 aligned pair7", {28'd0, lag_x[15:14], lag_y[15:14]}, 32'hF);
    check("R4 single aligned pair", hits, 1);

    // pseudo-random sweep with option toggling
    lfsr = 24'hACE1F3;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
      step(lfsr);
    end

    // R1: reset in the middle of activity
    do_reset();
    step('0);

    finish_run();
  end
endmodule